// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block keeps the inter-processor interrupt state of a single processor core. Other agents reach it over a simple 32-bit register bus. The bus can also carry a double-word access, which covers two adjacent words in one transfer. The block holds a pending-source word and a mask word. It also holds a small array of mailbox words that cores use to pass short messages to each other.

Pending bits cannot be written directly. A write to the set register ORs bits into the pending word. A write to the clear register removes bits from it. The single level interrupt toward the core is re-evaluated only when one of these two registers is written. Changing the mask by itself leaves the line as it is until the next set or clear write. Every access receives a registered response one cycle later. The response carries read data and an error pulse for illegal accesses.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset, the pending word, the mask word and every mailbox word read as zero, `irq_o` is low and `rsp_valid` is low.
- R2: A write to byte offset 0x08 ORs the written data into the pending word, which reads back at offset 0x00.
- R3: A write to byte offset 0x0C clears the pending bits that are set in the written data (pending AND NOT data).
- R4: Offset 0x00 is read-only. A write there leaves the pending word unchanged and pulses `rsp_err` in its response.
- R5: After a write to offset 0x08, `irq_o` goes high in the next cycle if the new pending word AND the mask is nonzero. Otherwise the line keeps its level. A set write of zero still re-evaluates the line.
- R6: After a write to offset 0x0C, `irq_o` goes low in the next cycle if the new pending word is zero and the mask (offset 0x04) is nonzero. Otherwise the line keeps its level, including when the mask is zero.
- R7: A write to the mask register at offset 0x04 stores the mask but does not change `irq_o`.
- R8: The mailbox words sit at byte offsets 0x20 to 0x3C, with word index (offset - 0x20) >> 2. Each word holds the last full 32-bit value written to it and returns it on a read.
- R9: These accesses return zero data and pulse `rsp_err` for one cycle: an offset in 0x10 to 0x1F, an offset of 0x40 or above, or an offset that is not a multiple of 4. Reads of 0x08 and 0x0C return zero without error.
- R10: When `bus_wide` is set, the access covers the words at `bus_addr` and `bus_addr+4`. Bits 31:0 of the data go to the lower address and bits 63:32 to the upper address, for both reads and writes. Each word is decoded on its own, and if either word is illegal the access reports an error.
- R11: `rsp_valid`, `rsp_rdata` and `rsp_err` appear exactly one cycle after the cycle in which `bus_valid` was high. In other cycles `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Double-word access covering two adjacent words |
| bus_addr | input | 7 | Byte offset inside the register window |
| bus_wdata | input | 64 | Write data; bits 63:32 are used only when wide |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 64 | Read data; upper word is zero for a narrow access |
| rsp_err | output | 1 | Illegal access pulse |
| irq_o | output | 1 | Level interrupt toward the core |

## Verification
Every result of this block is due one clock edge after the access that causes it. The response, the error pulse, the new interrupt level and any register change all show at that edge. The bench drives each access on a falling edge and checks the response and `irq_o` at the next falling edge, which is exactly one rising edge later. The vector table is ordered so that the interrupt level carries over from row to row. This lets rows that write the mask prove, at the next sample point, that the line did not move.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_STATUS = 3'd1,
    K_ENABLE = 3'd2,
    K_SET    = 3'd3,
    K_CLEAR  = 3'd4,
    K_MBOX   = 3'd5
  } kind_e;

  localparam int unsigned OFF_STATUS = 32'h00;
  localparam int unsigned OFF_ENABLE = 32'h04;
  localparam int unsigned OFF_SET    = 32'h08;
  localparam int unsigned OFF_CLEAR  = 32'h0C;
  localparam int unsigned MBOX_BASE  = 32'h20;

  // word slot of a mailbox byte offset
  function automatic logic [31:0] mbox_slot(input logic [31:0] byte_off);
    return (byte_off - MBOX_BASE) >> 2;
  endfunction

endpackage

// File: rtl/ipi_lane_decode.sv
module ipi_lane_decode
  import ipi_pkg::*;
#(
  parameter int AW         = 7,
  parameter int MBOX_WORDS = 8,
  parameter int IW         = 3
) (
  input  logic [AW:0]   addr,
  output kind_e         kind,
  output logic [IW-1:0] idx
);
  localparam logic [31:0] MBOX_END = MBOX_BASE + 4 * MBOX_WORDS;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    kind = K_NONE;
    idx  = IW'(mbox_slot(a32));
    if (a32[1:0] == 2'b00) begin
      if (a32 == OFF_STATUS)      kind = K_STATUS;
      else if (a32 == OFF_ENABLE) kind = K_ENABLE;
      else if (a32 == OFF_SET)    kind = K_SET;
      else if (a32 == OFF_CLEAR)  kind = K_CLEAR;
      else if (a32 >= MBOX_BASE && a32 < MBOX_END) kind = K_MBOX;
    end
  end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int LANES = 2,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we    [LANES],
  input  logic [IW-1:0] widx  [LANES],
  input  logic [DW-1:0] wdata [LANES],
  input  logic [IW-1:0] ridx  [LANES],
  output logic [DW-1:0] rdata [LANES]
);
  logic [DW-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] nxt;
    always_comb begin
      nxt = mem[w];
      for (int l = 0; l < LANES; l++)
        if (we[l] && (32'(widx[l]) == w)) nxt = wdata[l];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mem[w] <= '0;
      else        mem[w] <= nxt;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rdata[l] = (32'(ridx[l]) < WORDS) ? mem[ridx[l]] : '0;
  end

  // R8: a lane write lands in the addressed word
  p_mbox_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |=> mem[$past(widx[0])] == $past(wdata[0]));

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_pkg::*;
#(
  parameter int AW         = 7,
  parameter int DW         = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [AW-1:0]     bus_addr,
  input  logic [2*DW-1:0]   bus_wdata,
  output logic              rsp_valid,
  output logic [2*DW-1:0]   rsp_rdata,
  output logic              rsp_err,
  output logic              irq_o
);
  localparam int LANES = 2;
  localparam int IW    = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

  logic [DW-1:0] status_q, enable_q;

  // interrupt update rule applied on set/clear writes
  function automatic logic irq_eval(input logic cur, input logic set_w,
                                    input logic clr_w, input logic [DW-1:0] st,
                                    input logic [DW-1:0] en);
    if (set_w && (st != '0) && ((st & en) != '0)) return 1'b1;
    if (clr_w && (st == '0) && (en != '0))        return 1'b0;
    return cur;
  endfunction

  // per-lane decode
  logic [AW:0]   lane_addr [LANES];
  logic          lane_on   [LANES];
  logic [DW-1:0] lane_wd   [LANES];
  kind_e         lane_kind [LANES];
  logic [IW-1:0] lane_idx  [LANES];
  logic          mb_we     [LANES];
  logic [DW-1:0] mb_rd     [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_addr[l] = {1'b0, bus_addr} + (AW+1)'(4 * l);
    assign lane_on[l]   = bus_valid && ((l == 0) || bus_wide);
    assign lane_wd[l]   = bus_wdata[l*DW +: DW];
    assign mb_we[l]     = lane_on[l] && bus_write && (lane_kind[l] == K_MBOX);

    ipi_lane_decode #(.AW(AW), .MBOX_WORDS(MBOX_WORDS), .IW(IW)) i_dec (
      .addr (lane_addr[l]),
      .kind (lane_kind[l]),
      .idx  (lane_idx[l])
    );
  end

  ipi_mailbox #(.WORDS(MBOX_WORDS), .DW(DW), .LANES(LANES), .IW(IW)) i_mbox (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mb_we),
    .widx  (lane_idx),
    .wdata (lane_wd),
    .ridx  (lane_idx),
    .rdata (mb_rd)
  );

  // named events for the assertions
  logic          set_hit, clr_hit, en_hit, stat_wr_hit, bad_hit;
  logic [DW-1:0] set_bits, clr_bits, en_bits, status_nx;
  logic [2*DW-1:0] rd_nx;

  always_comb begin
    set_hit = 1'b0; clr_hit = 1'b0; en_hit = 1'b0; stat_wr_hit = 1'b0; bad_hit = 1'b0;
    set_bits = '0; clr_bits = '0; en_bits = enable_q;
    rd_nx = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_on[l]) begin
        if (lane_kind[l] == K_NONE) bad_hit = 1'b1;
        if (bus_write) begin
          case (lane_kind[l])
            K_SET:    begin set_hit = 1'b1; set_bits |= lane_wd[l]; end
            K_CLEAR:  begin clr_hit = 1'b1; clr_bits |= lane_wd[l]; end
            K_ENABLE: begin en_hit  = 1'b1; en_bits   = lane_wd[l]; end
            K_STATUS: begin stat_wr_hit = 1'b1; bad_hit = 1'b1; end
            default: ;
          endcase
        end else begin
          case (lane_kind[l])
            K_STATUS: rd_nx[l*DW +: DW] = status_q;
            K_ENABLE: rd_nx[l*DW +: DW] = enable_q;
            K_MBOX:   rd_nx[l*DW +: DW] = mb_rd[l];
            default:  rd_nx[l*DW +: DW] = '0;
          endcase
        end
      end
    end
    status_nx = (status_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      enable_q  <= '0;
      irq_o     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      status_q  <= status_nx;
      if (en_hit) enable_q <= en_bits;
      irq_o     <= irq_eval(irq_o, set_hit, clr_hit, status_nx, enable_q);
      rsp_valid <= bus_valid;
      rsp_rdata <= rd_nx;
      rsp_err   <= bus_valid && bad_hit;
    end
  end

  // R2: set bits appear in the pending word
  p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit && !clr_hit |=> (status_q & $past(set_bits)) == $past(set_bits));

  // R4: a status write alone leaves the pending word untouched
  p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_hit && !set_hit && !clr_hit |=> $stable(status_q) && rsp_err);

  // R5: set write with an unmasked pending bit raises the line
  p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit && ((status_nx & enable_q) != '0) |=> irq_o);

  // R6: clear write emptying the pending word with mask nonzero lowers it
  p_irq_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !set_hit && (status_nx == '0) && (enable_q != '0) |=> !irq_o);

  // R7: without set or clear writes the line holds
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_hit && !clr_hit |=> $stable(irq_o));

  // R9: an error pulse only travels with a response
  p_err_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R11: every request gets a response one cycle later
  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);

endmodule

// File: tb/test_ipi_core_regs.sv
`timescale 1ns/1ps
module test_ipi_core_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        rsp_valid, rsp_err, irq_o;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ipi_core_regs i_ipi_core_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [6:0]  addr;
    logic [63:0] wd;
    logic        chk;
    logic [63:0] rd;
    logic        err;
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,7'h04,64'h0F0,1'b0,64'h0,1'b0,1'b0,8'd7},          // R7 mask F0
    '{1'b1,1'b0,7'h08,64'h003,1'b0,64'h0,1'b0,1'b0,8'd5},          // R5 masked off
    '{1'b0,1'b0,7'h00,64'h0,1'b1,64'h003,1'b0,1'b0,8'd2},          // R2 read back
    '{1'b1,1'b0,7'h08,64'h010,1'b0,64'h0,1'b0,1'b1,8'd5},          // R5 raise
    '{1'b1,1'b0,7'h0C,64'h001,1'b0,64'h0,1'b0,1'b1,8'd6},          // R6 still pending
    '{1'b0,1'b0,7'h00,64'h0,1'b1,64'h012,1'b0,1'b1,8'd3},          // R3 read back
    '{1'b1,1'b0,7'h0C,64'h012,1'b0,64'h0,1'b0,1'b0,8'd6},          // R6 lower
    '{1'b1,1'b0,7'h04,64'h000,1'b0,64'h0,1'b0,1'b0,8'd7},          // R7 mask 0
    '{1'b1,1'b0,7'h08,64'h020,1'b0,64'h0,1'b0,1'b0,8'd5},          // R5 no raise
    '{1'b1,1'b0,7'h04,64'h020,1'b0,64'h0,1'b0,1'b0,8'd7},          // R7 unmask, line holds
    '{1'b1,1'b0,7'h08,64'h000,1'b0,64'h0,1'b0,1'b1,8'd5},          // R5 zero set re-evaluates
    '{1'b1,1'b0,7'h04,64'h000,1'b0,64'h0,1'b0,1'b1,8'd7},          // R7 mask off, line holds
    '{1'b1,1'b0,7'h0C,64'h020,1'b0,64'h0,1'b0,1'b1,8'd6},          // R6 mask zero keeps line
    '{1'b1,1'b0,7'h04,64'h0FF,1'b0,64'h0,1'b0,1'b1,8'd7},          // R7
    '{1'b1,1'b0,7'h0C,64'h000,1'b0,64'h0,1'b0,1'b0,8'd6},          // R6 lower now
    '{1'b1,1'b0,7'h00,64'hFFFF,1'b0,64'h0,1'b1,1'b0,8'd4},         // R4 illegal write
    '{1'b0,1'b0,7'h00,64'h0,1'b1,64'h0,1'b0,1'b0,8'd4},            // R4 unchanged
    '{1'b1,1'b0,7'h20,64'hA5A50001,1'b0,64'h0,1'b0,1'b0,8'd8},     // R8
    '{1'b1,1'b0,7'h3C,64'h5A5A0008,1'b0,64'h0,1'b0,1'b0,8'd8},     // R8
    '{1'b0,1'b0,7'h20,64'h0,1'b1,64'hA5A50001,1'b0,1'b0,8'd8},     // R8
    '{1'b0,1'b0,7'h3C,64'h0,1'b1,64'h5A5A0008,1'b0,1'b0,8'd8},     // R8
    '{1'b0,1'b0,7'h10,64'h0,1'b1,64'h0,1'b1,1'b0,8'd9},            // R9 gap
    '{1'b0,1'b0,7'h40,64'h0,1'b1,64'h0,1'b1,1'b0,8'd9},            // R9 past mailbox
    '{1'b0,1'b0,7'h22,64'h0,1'b1,64'h0,1'b1,1'b0,8'd9},            // R9 misaligned
    '{1'b0,1'b0,7'h08,64'h0,1'b1,64'h0,1'b0,1'b0,8'd9},            // R9 set reads zero
    '{1'b1,1'b1,7'h28,64'h00002222_00001111,1'b0,64'h0,1'b0,1'b0,8'd10}, // R10
    '{1'b0,1'b1,7'h28,64'h0,1'b1,64'h00002222_00001111,1'b0,1'b0,8'd10}, // R10
    '{1'b0,1'b1,7'h3C,64'h0,1'b1,64'h00000000_5A5A0008,1'b1,1'b0,8'd10}, // R10 upper illegal
    '{1'b1,1'b1,7'h08,64'h00000000_00000004,1'b0,64'h0,1'b0,1'b1,8'd10}, // R10 set+clear pair
    '{1'b0,1'b1,7'h00,64'h0,1'b1,64'h000000FF_00000004,1'b0,1'b1,8'd10}, // R10
    '{1'b0,1'b0,7'h2C,64'h0,1'b1,64'h00002222,1'b0,1'b1,8'd8}      // R8 upper lane landed
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, result due at the next falling edge
  task automatic access(input logic wr, input logic wide, input logic [6:0] a,
                        input logic [63:0] wd);
    bus_valid = 1'b1; bus_write = wr; bus_wide = wide; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 irq at reset", 64'(irq_o), 64'h0);
    check("R1 rsp_valid at reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      access(VEC[i].wr, VEC[i].wide, VEC[i].addr, VEC[i].wd);
      check({tag, " R11 valid"}, 64'(rsp_valid), 64'h1);
      check({tag, " err"}, 64'(rsp_err), 64'(VEC[i].err));
      check({tag, " irq"}, 64'(irq_o), 64'(VEC[i].irq));
      if (VEC[i].chk) check({tag, " rdata"}, rsp_rdata, VEC[i].rd);
    end

    @(negedge clk);
    check("R11 idle no response", 64'(rsp_valid), 64'h0);
    check("R9 err one cycle", 64'(rsp_err), 64'h0);

    // reset in the middle of activity: irq is high, registers are filled
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", 64'(irq_o), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b1, 7'h00, 64'h0);
    check("R1 status/mask cleared", rsp_rdata, 64'h0);
    access(1'b0, 1'b1, 7'h20, 64'h0);
    check("R1 mailbox cleared", rsp_rdata, 64'h0);
    access(1'b0, 1'b0, 7'h3C, 64'h0);
    check("R1 last mailbox cleared", rsp_rdata, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule